// File: doc/BRIEF.md
# Divided Clock Selector with Output Gate

The block builds one output clock from three slow source clocks. Each source first passes through its own integer divider, and a 2-bit select field then picks which divided source reaches the output. The fourth select code does not choose a source: it parks the output low. The whole block runs in a single fast system clock domain. The source clocks come in as oversampled signals through synchronisers, so the output and every status bit are registered on the system clock.

Software programs four fields through a simple word-wide write port: the select field and three 5-bit divider fields. It reads them back, together with a 3-bit running status, through a registered read port. When the select field changes, the output finishes its current high pulse and holds low. It then waits for the new divided source to reach a low phase and resumes on that source's next rising edge. Only then does the running bit of the new source assert, so software can poll it to see that the switch has completed. A divider change is held back until the divider's own next period start, so neither operation can produce a short pulse.

Top module: `divclk_selector`

## Requirements
- R1: After reset the select field reads 3 (output off), every divider field reads 0, `clk_out` is low and `running` is 0.
- R2: Register addresses: 0 holds the select field in bits [1:0]; 1, 2 and 3 hold the divider fields of sources 0, 1 and 2 in bits [4:0]; 4 returns `running` in bits [2:0]. Unused bits read 0. `rd_data` shows the register addressed by `rd_addr` one clock after it is presented.
- R3: The divide ratio is the divider field plus one (1 to 32). Each high and each low level of `clk_out` lasts exactly ratio half-periods of the selected source. Ratio 1 reproduces the source.
- R4: Select code 3 keeps `clk_out` low and `running` at 0 once any high pulse in progress has ended.
- R5: `running` bit i is 1 only when the select field is i and `clk_out` is toggling from source i; at most one bit is set.
- R6: Changing the select field while the output is on restarts the output on the new source, and the new source's running bit asserts while the others are 0.
- R7: The output ratio always comes from the divider field of the selected source. Writing the divider field of a source that is not selected leaves the output period unchanged.
- R8: A new divider value takes effect only at the start of a divided period. While it settles, every high pulse has either the old length or the new length.
- R9: A source switch is glitch-free: the output holds low across the changeover, rises only on a genuine rising edge of the new divided source, and every high pulse during the switch has the full length of either the old or the new source.
- R10: Selecting a source again after the off code restarts the output with that source's ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | 3 | The three source clocks, asynchronous to `clk` |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Register address for a write |
| wr_data | input | 5 | Write data |
| rd_addr | input | 3 | Register address for a read |
| rd_data | output | 5 | Registered read data |
| clk_out | output | 1 | Divided, selected and gated output clock |
| running | output | 3 | Per-source running status, one-hot or zero |

## Verification
The assertions assume that every source half-period spans several system clock cycles, so that the synchronisers see each level. They also assume that writes are single-cycle strobes. The stimulus keeps to this by using source half-periods of 5, 7 and 9 system cycles, with source edges placed well away from the system clock edges. Divider and select writes are issued at arbitrary phases of the divided output, so that both the boundary hold-off and the drain-then-arm switch sequence are exercised from high and from low output levels.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int SRC_N = 3;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_OFF = 2'd3;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ARM   = 2'd2,
    ST_RUN   = 2'd3
  } sw_state_t;
endpackage

// File: rtl/dcs_edge_sync.sv
module dcs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  // any change of the synchronised level counts as one source edge
  assign edge_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/dcs_ratio_div.sv
module dcs_ratio_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] field_i,
  output logic             lvl_o
);
  localparam int RW = DIV_W + 1;
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] ecnt_q;
  logic [RW-1:0] ratio_q;
  logic          phase_q;

  // level toggles every ratio_q source edges; new ratio loads at period start
  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt_q  <= '0;
      ratio_q <= ONE;
      phase_q <= 1'b0;
    end else if (edge_i) begin
      if (ecnt_q == ratio_q - ONE) begin
        ecnt_q  <= '0;
        phase_q <= ~phase_q;
        if (!phase_q) ratio_q <= {1'b0, field_i} + ONE;
      end else begin
        ecnt_q <= ecnt_q + ONE;
      end
    end
  end

  assign lvl_o = phase_q;

  // R8: the active ratio changes only together with a rising output level
  a_r8_ratio_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_q) |-> $rose(phase_q));

  // R3: the active ratio is never zero
  a_r3_ratio_nonzero: assert property (@(posedge clk) disable iff (rst)
    ratio_q != '0);
endmodule

// File: rtl/dcs_regs.sv
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DIV_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [SRC_N-1:0]       running_i,
  output logic [DIV_W-1:0]       rd_data,
  output logic [SEL_W-1:0]       sel_o,
  output logic [SRC_N*DIV_W-1:0] div_o
);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SRC_N + 1);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SEL_OFF;
    else if (wr_en && wr_addr == A_SEL) sel_q <= wr_data[SEL_W-1:0];
  end
  assign sel_o = sel_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_div
    logic [DIV_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i + 1)) q <= wr_data;
    end
    assign div_o[i*DIV_W +: DIV_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_addr == A_SEL) begin
        rd_data[SEL_W-1:0] <= sel_q;
      end else if (rd_addr == A_STAT) begin
        rd_data[SRC_N-1:0] <= running_i;
      end else begin
        for (int k = 0; k < SRC_N; k++)
          if (rd_addr == ADDR_W'(k + 1)) rd_data <= div_o[k*DIV_W +: DIV_W];
      end
    end
  end
endmodule

// File: rtl/dcs_switch.sv
module dcs_switch
  import dcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SRC_N-1:0] lvl_i,
  output logic             clk_out,
  output logic [SRC_N-1:0] running
);
  sw_state_t        st_q;
  logic [SEL_W-1:0] cur_q;
  logic             out_q;
  logic [SRC_N-1:0] run_q;
  logic             cur_lvl;
  logic [SRC_N-1:0] cur_hot;

  assign cur_lvl = lvl_i[cur_q];
  assign cur_hot = SRC_N'(1) << cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      cur_q <= '0;
      out_q <= 1'b0;
      run_q <= '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          out_q <= 1'b0;
          run_q <= '0;
          if (sel_i != SEL_OFF) begin
            cur_q <= sel_i;
            st_q  <= ST_ARM;
          end
        end
        ST_ARM: begin
          out_q <= 1'b0;
          run_q <= '0;
          if (sel_i == SEL_OFF)  st_q  <= ST_OFF;
          else if (sel_i != cur_q) cur_q <= sel_i;
          else if (!cur_lvl)     st_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (sel_i != cur_q) begin
            run_q <= '0;
            if (cur_lvl) begin
              out_q <= 1'b1;
              st_q  <= ST_DRAIN;
            end else begin
              out_q <= 1'b0;
              if (sel_i == SEL_OFF) st_q <= ST_OFF;
              else begin
                cur_q <= sel_i;
                st_q  <= ST_ARM;
              end
            end
          end else begin
            out_q <= cur_lvl;
            run_q <= (run_q != '0 || cur_lvl) ? cur_hot : '0;
          end
        end
        default: begin
          run_q <= '0;
          if (cur_lvl) begin
            out_q <= 1'b1;
          end else begin
            out_q <= 1'b0;
            if (sel_i == SEL_OFF) st_q <= ST_OFF;
            else begin
              cur_q <= sel_i;
              st_q  <= ST_ARM;
            end
          end
        end
      endcase
    end
  end

  assign clk_out = out_q;
  assign running = run_q;

  // R9: the output can only rise while a source is fully armed and running
  a_r9_rise_only_in_run: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(st_q) == ST_RUN);

  // R5: a running bit names the source held in the select field
  a_r5_running_matches_select: assert property (@(posedge clk) disable iff (rst)
    (run_q != '0) |-> run_q == (SRC_N'(1) << $past(sel_i)));

  // R5: at most one source reported running
  a_r5_running_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(run_q));
endmodule

// File: rtl/divclk_selector.sv
module divclk_selector
  import dcs_pkg::*;
#(
  parameter int DIV_W       = 5,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DIV_W-1:0]  rd_data,
  output logic              clk_out,
  output logic [SRC_N-1:0]  running
);
  logic [SEL_W-1:0]       sel;
  logic [SRC_N*DIV_W-1:0] div_f;
  logic [SRC_N-1:0]       src_edge;
  logic [SRC_N-1:0]       lvl;

  dcs_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .running_i(running), .rd_data(rd_data),
    .sel_o(sel), .div_o(div_f)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    dcs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(src_clk[i]), .edge_o(src_edge[i])
    );
    dcs_ratio_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .edge_i(src_edge[i]),
      .field_i(div_f[i*DIV_W +: DIV_W]), .lvl_o(lvl[i])
    );
  end

  dcs_switch u_sw (
    .clk(clk), .rst(rst), .sel_i(sel), .lvl_i(lvl),
    .clk_out(clk_out), .running(running)
  );
endmodule

// File: tb/tb_divclk_selector.sv
module tb_divclk_selector;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] src_clk = 3'b000;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [4:0] rd_data;
  logic       clk_out;
  logic [2:0] running;

  localparam int HALF0 = 5, HALF1 = 7, HALF2 = 9;

  always #10 clk = ~clk;
  initial begin #7; forever #(HALF0*20) src_clk[0] = ~src_clk[0]; end
  initial begin #7; forever #(HALF1*20) src_clk[1] = ~src_clk[1]; end
  initial begin #7; forever #(HALF2*20) src_clk[2] = ~src_clk[2]; end

  divclk_selector dut (
    .clk(clk), .rst(rst), .src_clk(src_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_out(clk_out), .running(running)
  );

  int errs = 0, checks = 0, mon_done = 0;

  typedef struct { int hi; string req; } exp_t;
  exp_t sb_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [4:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  // driver side of the scoreboard: push an expected level length, wait for monitor
  task automatic expect_period(int hi, string req);
    int d;
    exp_t it;
    d = mon_done;
    it.hi = hi; it.req = req;
    sb_q.push_back(it);
    wait (mon_done > d);
  endtask

  // monitor: measures one full high and low level of clk_out per item
  initial begin
    exp_t it;
    int hi, lo;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge clk);
      while (clk_out) @(negedge clk);
      while (!clk_out) @(negedge clk);
      hi = 0;
      while (clk_out) begin hi++; @(negedge clk); end
      lo = 0;
      while (!clk_out) begin lo++; @(negedge clk); end
      chk(hi == it.hi, it.req, "high length", hi, it.hi);
      chk(lo == it.hi, it.req, "low length", lo, it.hi);
      mon_done++;
    end
  end

  task automatic wait_run(logic [2:0] exp, string req);
    int n = 0;
    @(negedge clk);
    while (running !== exp && n < 4000) begin n++; @(negedge clk); end
    chk(running === exp, req, "running bits", int'(running), int'(exp));
  endtask

  // every complete high pulse in the window must be length a or b
  task automatic watch(int cycles, int a, int b, string req);
    int run = 0, bad = 0, badv = 0, np = 0;
    bit skip;
    @(negedge clk);
    skip = clk_out;
    repeat (cycles) begin
      if (clk_out) run++;
      else begin
        if (run > 0 && !skip) begin
          np++;
          if (run != a && run != b) begin bad++; badv = run; end
        end
        skip = 1'b0;
        run = 0;
      end
      @(negedge clk);
    end
    chk(bad == 0, req, "pulse length in transition", badv, a);
    chk(np > 0, req, "pulses seen in transition", np, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [4:0] v;
    int highs;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(clk_out == 1'b0, "R1", "clk_out after reset", int'(clk_out), 0);
    chk(running == 3'b000, "R1", "running after reset", int'(running), 0);
    rd(3'd0, v); chk(v == 5'd3, "R1", "select field", int'(v), 3);
    rd(3'd2, v); chk(v == 5'd0, "R1", "divider 1 field", int'(v), 0);
    rd(3'd4, v); chk(v == 5'd0, "R2", "status read", int'(v), 0);

    // R3 ratio 1 passes source 0
    wr(3'd1, 5'd0);
    wr(3'd0, 5'd0);
    wait_run(3'b001, "R6");
    expect_period(HALF0, "R3");

    // R8 divider changes at a period boundary
    wr(3'd1, 5'd3);
    watch(300, HALF0, 4*HALF0, "R8");
    expect_period(4*HALF0, "R8");
    wr(3'd1, 5'd9);
    watch(500, 4*HALF0, 10*HALF0, "R8");
    expect_period(10*HALF0, "R3");

    // R9 glitch-free switch to source 2
    wr(3'd3, 5'd1);
    wr(3'd0, 5'd2);
    watch(600, 10*HALF0, 2*HALF2, "R9");
    wait_run(3'b100, "R6");
    expect_period(2*HALF2, "R9");

    // R3 maximum ratio
    wr(3'd3, 5'd31);
    expect_period(32*HALF2, "R3");

    // R4 off code gates the output
    wr(3'd0, 5'd3);
    repeat (400) @(negedge clk);
    highs = 0;
    repeat (600) begin
      if (clk_out || running != 3'b000) highs++;
      @(negedge clk);
    end
    chk(highs == 0, "R4", "cycles with output or running while off", highs, 0);
    rd(3'd4, v); chk(v == 5'd0, "R4", "status while off", int'(v), 0);

    // R10 re-enable on source 1
    wr(3'd2, 5'd2);
    wr(3'd0, 5'd1);
    wait_run(3'b010, "R10");
    rd(3'd4, v); chk(v == 5'd2, "R5", "status read source 1", int'(v), 2);
    expect_period(3*HALF1, "R10");

    // R7 non-selected dividers have no effect
    wr(3'd1, 5'd31);
    wr(3'd3, 5'd0);
    rd(3'd1, v); chk(v == 5'd31, "R2", "divider 0 readback", int'(v), 31);
    expect_period(3*HALF1, "R7");

    // R7 switch back: source 0 divider now applies
    wr(3'd0, 5'd0);
    wait_run(3'b001, "R5");
    expect_period(32*HALF0, "R7");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule